// File: doc/BRIEF.md
# Frame Interrupt Source Selector

This block decides when an image-pipeline input interface raises its once-per-frame interrupt. The interrupt can come from three places: the start of vertical sync on one of two live sensor paths, the start of vertical sync from an internal timing generator, or an end-of-frame strobe. The choice depends on four configuration inputs: a path-select bit, a 2-bit input-source field for each path, and a one-shot/continuous mode bit. When the governing source field is zero, data comes from a live path. Any non-zero value means data is read from memory.

The configuration is captured into shadow registers. The shadow is reloaded only at the frame event that the current shadow configuration selects, so a reconfiguration never produces a pulse in the middle of a frame. Host-side controls set and clear an interrupt enable bit and clear a sticky underflow flag.

In live mode, the block raises the underflow flag when the downstream consumer asks for data and none is valid. In memory mode it does not raise underflow. Instead it drops a clock-enable output so that the consumer stalls until data arrives.

Top module: `frame_irq_sel`

## Requirements
- R1: A synchronous active-high `rst` clears `irq`, `irq_en`, `udf_flag` and the edge-detect registers. On the same edge it loads the shadow configuration from the `cfg_*` inputs.
- R2: `en_set` sets `irq_en` and `en_clr` clears it; when both are high, set wins. `irq` can be high only when `irq_en` was 1 in the cycle before.
- R3: Shadow select 0 makes `vs_live_a` and `cfg_src_a` govern. Shadow select 1 makes `vs_live_b` and `cfg_src_b` govern. An edge on the other live path causes no interrupt.
- R4: When the governing source field is 0, a rising edge of the selected live vertical sync sampled at a clock edge makes `irq` high for the following cycle.
- R5: When the governing source field is 1, 2 or 3 and the one-shot bit is 1, a rising edge of `eof_strobe` is the frame event.
- R6: When the governing source field is 1, 2 or 3 and the one-shot bit is 0, a rising edge of `vs_tgen` is the frame event.
- R7: `irq` is a one-cycle pulse per event. A sync or end-of-frame signal held high gives no further pulse.
- R8: In live mode, `out_req` high with `in_valid` low sets `udf_flag` on the next edge. The flag holds until `udf_clr_w1` is written as 1. A new underflow in the same cycle as the clear wins.
- R9: In memory mode, `out_ce` equals `in_valid` and `udf_flag` is never set. In live mode, `out_ce` stays 1.
- R10: Changes on `cfg_*` take effect only after the next frame event of the current shadow configuration. That event occurs whether or not the interrupt is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel | input | 1 | Path select: 0 path A, 1 path B |
| cfg_src_a | input | SRC_W | Input-source field for path A (0 = live) |
| cfg_src_b | input | SRC_W | Input-source field for path B (0 = live) |
| cfg_oneshot | input | 1 | 1 one-shot, 0 continuous |
| vs_live_a | input | 1 | Vertical sync of live path A |
| vs_live_b | input | 1 | Vertical sync of live path B |
| vs_tgen | input | 1 | Vertical sync of internal timing generator |
| eof_strobe | input | 1 | End-of-frame indication |
| en_set | input | 1 | Set interrupt enable |
| en_clr | input | 1 | Clear interrupt enable |
| udf_clr_w1 | input | 1 | Write-one-to-clear for underflow flag |
| in_valid | input | 1 | Input data available |
| out_req | input | 1 | Downstream data request |
| out_ce | output | 1 | Output clock enable (stall when low) |
| irq | output | 1 | Frame interrupt pulse |
| irq_en | output | 1 | Interrupt enable state |
| udf_flag | output | 1 | Sticky underflow status |

## Verification
The bench changes the configuration in the middle of a frame and drives an edge on the newly chosen path. A design that applies the new configuration immediately would fire early there. It holds sync and end-of-frame signals high across several cycles, which a level-sensitive design would answer with repeated pulses. It drives underflow conditions in memory mode, where a design that ignored the mode would flag a false underflow or fail to stall. It also drives a simultaneous clear and new underflow, and a simultaneous enable set and clear, to expose wrong priority.

// File: rtl/frame_irq_sel.sv
module frame_irq_sel #(
  parameter int SRC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_sel,
  input  logic [SRC_W-1:0] cfg_src_a,
  input  logic [SRC_W-1:0] cfg_src_b,
  input  logic             cfg_oneshot,
  input  logic             vs_live_a,
  input  logic             vs_live_b,
  input  logic             vs_tgen,
  input  logic             eof_strobe,
  input  logic             en_set,
  input  logic             en_clr,
  input  logic             udf_clr_w1,
  input  logic             in_valid,
  input  logic             out_req,
  output logic             out_ce,
  output logic             irq,
  output logic             irq_en,
  output logic             udf_flag
);

  logic             sh_sel, sh_oneshot;
  logic [SRC_W-1:0] sh_src_a, sh_src_b;
  logic             va_q, vb_q, vt_q, eof_q;

  wire [SRC_W-1:0] gov_src   = sh_sel ? sh_src_b : sh_src_a;
  wire             mem_mode  = |gov_src;
  wire             live_rise = sh_sel ? (vs_live_b & ~vb_q) : (vs_live_a & ~va_q);
  wire             tg_rise   = vs_tgen & ~vt_q;
  wire             eof_rise  = eof_strobe & ~eof_q;
  wire             frame_evt = !mem_mode ? live_rise : (sh_oneshot ? eof_rise : tg_rise);
  wire             udf_hit   = !mem_mode & out_req & !in_valid;

  assign out_ce = !mem_mode | in_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      va_q       <= 1'b0;
      vb_q       <= 1'b0;
      vt_q       <= 1'b0;
      eof_q      <= 1'b0;
      irq        <= 1'b0;
      irq_en     <= 1'b0;
      udf_flag   <= 1'b0;
      sh_sel     <= cfg_sel;
      sh_src_a   <= cfg_src_a;
      sh_src_b   <= cfg_src_b;
      sh_oneshot <= cfg_oneshot;
    end else begin
      va_q     <= vs_live_a;
      vb_q     <= vs_live_b;
      vt_q     <= vs_tgen;
      eof_q    <= eof_strobe;
      irq      <= frame_evt & irq_en;
      irq_en   <= en_set ? 1'b1 : (en_clr ? 1'b0 : irq_en);
      udf_flag <= udf_hit ? 1'b1 : (udf_clr_w1 ? 1'b0 : udf_flag);
      if (frame_evt) begin
        sh_sel     <= cfg_sel;
        sh_src_a   <= cfg_src_a;
        sh_src_b   <= cfg_src_b;
        sh_oneshot <= cfg_oneshot;
      end
    end
  end

  a_r2_irq_needs_en: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en));

  a_r8_udf_sticky: assert property (@(posedge clk) disable iff (rst)
    (udf_flag && !udf_clr_w1) |=> udf_flag);

  a_r9_no_udf_in_mem: assert property (@(posedge clk) disable iff (rst)
    (mem_mode && !udf_flag) |=> !udf_flag);

  a_r9_stall_only_mem: assert property (@(posedge clk) disable iff (rst)
    !out_ce |-> (mem_mode && !in_valid));

  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_evt |=> $stable({sh_sel, sh_src_a, sh_src_b, sh_oneshot}));

endmodule

// File: tb/frame_irq_sel_tb.sv
`timescale 1ns/1ps
module frame_irq_sel_tb;
  localparam int SRC_W = 2;

  logic clk = 0, rst = 1;
  logic cfg_sel = 0, cfg_oneshot = 0;
  logic [SRC_W-1:0] cfg_src_a = 0, cfg_src_b = 0;
  logic vs_live_a = 0, vs_live_b = 0, vs_tgen = 0, eof_strobe = 0;
  logic en_set = 0, en_clr = 0, udf_clr_w1 = 0, in_valid = 1, out_req = 0;
  logic out_ce, irq, irq_en, udf_flag;

  int checks = 0, errors = 0;

  bit m_sel, m_one, m_va, m_vb, m_vt, m_eof, m_irq, m_en, m_udf;
  bit [SRC_W-1:0] m_sa, m_sb;

  always #4 clk = ~clk;

  frame_irq_sel #(.SRC_W(SRC_W)) u_dut (
    .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cfg_src_a(cfg_src_a), .cfg_src_b(cfg_src_b),
    .cfg_oneshot(cfg_oneshot), .vs_live_a(vs_live_a), .vs_live_b(vs_live_b), .vs_tgen(vs_tgen),
    .eof_strobe(eof_strobe), .en_set(en_set), .en_clr(en_clr), .udf_clr_w1(udf_clr_w1),
    .in_valid(in_valid), .out_req(out_req), .out_ce(out_ce), .irq(irq), .irq_en(irq_en),
    .udf_flag(udf_flag));

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit mem_mode_m();
    return (m_sel ? m_sb : m_sa) != 0;
  endfunction

  function automatic bit evt_m();
    if (!mem_mode_m()) return m_sel ? (vs_live_b & ~m_vb) : (vs_live_a & ~m_va);
    if (m_one) return eof_strobe & ~m_eof;
    return vs_tgen & ~m_vt;
  endfunction

  function automatic string mode_tag();
    if (!mem_mode_m()) return "R4";
    return m_one ? "R5" : "R6";
  endfunction

  task automatic cyc();
    bit e, n_irq, n_en, n_udf, was_rst;
    string itag, utag;
    #1;
    if (!rst) chk(out_ce, !mem_mode_m() || in_valid, "R9");
    was_rst = rst;
    itag = m_en ? mode_tag() : "R2";
    utag = mem_mode_m() ? "R9" : "R8";
    e = evt_m();
    n_irq = e & m_en;
    n_en  = en_set ? 1'b1 : (en_clr ? 1'b0 : m_en);
    n_udf = (!mem_mode_m() && out_req && !in_valid) ? 1'b1 : (udf_clr_w1 ? 1'b0 : m_udf);
    @(posedge clk);
    if (rst) begin
      m_va = 0; m_vb = 0; m_vt = 0; m_eof = 0; m_irq = 0; m_en = 0; m_udf = 0;
      m_sel = cfg_sel; m_sa = cfg_src_a; m_sb = cfg_src_b; m_one = cfg_oneshot;
    end else begin
      if (e) begin m_sel = cfg_sel; m_sa = cfg_src_a; m_sb = cfg_src_b; m_one = cfg_oneshot; end
      m_va = vs_live_a; m_vb = vs_live_b; m_vt = vs_tgen; m_eof = eof_strobe;
      m_irq = n_irq; m_en = n_en; m_udf = n_udf;
    end
    @(negedge clk);
    if (was_rst) begin
      chk(irq, 1'b0, "R1"); chk(irq_en, 1'b0, "R1"); chk(udf_flag, 1'b0, "R1");
    end else begin
      chk(irq, m_irq, itag); chk(irq_en, m_en, "R2"); chk(udf_flag, m_udf, utag);
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    rst = 1; cyc(); cyc(); rst = 0;
    en_set = 1; cyc(); en_set = 0;
    // R4 live edge on path A, then R7 held high
    vs_live_a = 1; cyc(); chk(irq, 1'b1, "R4");
    cyc(); chk(irq, 1'b0, "R7");
    vs_live_a = 0; cyc();
    // R10 mid-frame select change not yet active
    cfg_sel = 1; vs_live_b = 1; cyc(); chk(irq, 1'b0, "R10");
    vs_live_b = 0; cyc();
    vs_live_a = 1; cyc(); chk(irq, 1'b1, "R10");
    vs_live_a = 0; cyc();
    // R3 path B now governs
    vs_live_a = 1; cyc(); chk(irq, 1'b0, "R3");
    vs_live_b = 1; cyc(); chk(irq, 1'b1, "R3");
    // move to memory one-shot on path B
    cfg_src_b = 1; cfg_oneshot = 1; vs_live_b = 0; cyc();
    vs_live_b = 1; cyc(); chk(irq, 1'b1, "R4");
    eof_strobe = 1; cyc(); chk(irq, 1'b1, "R5");
    cyc(); chk(irq, 1'b0, "R7");
    eof_strobe = 0;
    out_req = 1; in_valid = 0; #1 chk(out_ce, 1'b0, "R9"); cyc(); chk(udf_flag, 1'b0, "R9");
    out_req = 0; in_valid = 1;
    // continuous on memory path
    cfg_oneshot = 0; eof_strobe = 1; cyc(); eof_strobe = 0; cyc();
    vs_tgen = 1; cyc(); chk(irq, 1'b1, "R6");
    cfg_sel = 0; cfg_src_a = 0; vs_tgen = 0; cyc();
    vs_tgen = 1; cyc(); vs_tgen = 0;
    out_req = 1; in_valid = 0; cyc(); chk(udf_flag, 1'b1, "R8");
    out_req = 0; in_valid = 1; cyc(); chk(udf_flag, 1'b1, "R8");
    udf_clr_w1 = 1; out_req = 1; in_valid = 0; cyc(); chk(udf_flag, 1'b1, "R8");
    out_req = 0; in_valid = 1; cyc(); chk(udf_flag, 1'b0, "R8");
    udf_clr_w1 = 0;
    en_set = 1; en_clr = 1; cyc(); chk(irq_en, 1'b1, "R2");
    en_set = 0; cyc(); chk(irq_en, 1'b0, "R2");
    en_clr = 0; vs_live_a = 0; cyc();
    vs_live_a = 1; cyc(); chk(irq, 1'b0, "R2");
    for (int i = 0; i < 4000; i++) begin
      rst = ($urandom % 600) == 0;
      if (($urandom % 8) == 0) vs_live_a = ~vs_live_a;
      if (($urandom % 8) == 0) vs_live_b = ~vs_live_b;
      if (($urandom % 8) == 0) vs_tgen = ~vs_tgen;
      eof_strobe = ($urandom % 12) == 0 ? ~eof_strobe : eof_strobe;
      if (($urandom % 24) == 0) begin
        cfg_sel = $urandom; cfg_src_a = ($urandom % 2) ? 0 : SRC_W'($urandom);
        cfg_src_b = ($urandom % 2) ? 0 : SRC_W'($urandom); cfg_oneshot = $urandom;
      end
      en_set = ($urandom % 20) == 0;
      en_clr = ($urandom % 25) == 0;
      udf_clr_w1 = ($urandom % 10) == 0;
      in_valid = ($urandom % 4) != 0;
      out_req = $urandom;
      cyc();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule